// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block decides, once per one-second update of a real-time clock, whether the current time has reached a programmed alarm time. It takes the seconds, minutes and hours bytes of the running clock and three alarm bytes, decodes them, and compares them field by field. A single-cycle pulse on `alarm_o` reports a hit. The time counter, interrupt enabling and register access sit outside the block.

Each byte is read either as packed BCD (tens digit in the upper nibble) or as a plain binary number, chosen by one mode input. Hours may be kept in 24-hour form or in 12-hour form with bit 7 as the PM marker. In 12-hour form both the current hour and the alarm hour are brought to a 0–23 value before they are compared. Any alarm byte whose two top bits are both set acts as a wildcard and matches every current value of its field.

A small state machine sequences the work. In ST_IDLE it waits for the update strobe. The strobe captures the comparison result and moves the machine to ST_EVAL. From ST_EVAL it goes to ST_FIRE on a hit, or back to ST_IDLE on a miss. ST_FIRE drives the pulse and returns to ST_IDLE. A strobe seen in any state restarts the sequence in ST_EVAL.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset `alarm_o` is low and stays low until an update strobe has been evaluated as a hit.
- R2: A strobe sampled at clock edge k with a hit gives `alarm_o` high for exactly one cycle, from edge k+2. Input changes after edge k have no effect on that result.
- R3: A strobe in the cycle right after another strobe discards the earlier evaluation; only the later strobe's result can produce a pulse.
- R4: An alarm byte with bits 7:6 equal to 2'b11 matches every current value of its field.
- R5: With `bin_mode_i` low, each byte decodes as upper nibble times ten plus lower nibble.
- R6: With `bin_mode_i` high, each byte is compared as its unsigned binary value.
- R7: With `h24_i` low, bit 7 of each hour byte is removed before decoding, the decoded value is taken modulo 12, and 12 is added when bit 7 was set; current and alarm hours are both treated this way.
- R8: With `h24_i` high, the hour bytes are decoded with no 12-hour conversion, and bit 7 stays part of the value.
- R9: With all three alarm bytes wildcards, every strobe that is not followed at once by another strobe produces a pulse.
- R10: Without a strobe, `alarm_o` stays low however well the inputs match.
- R11: A pulse needs every non-wildcard field to match; a mismatch in any single field blocks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second update strobe |
| bin_mode_i | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| h24_i | input | 1 | 1 = 24-hour hours, 0 = 12-hour hours with PM in bit 7 |
| cur_sec_i | input | 8 | Current seconds byte |
| cur_min_i | input | 8 | Current minutes byte |
| cur_hr_i | input | 8 | Current hours byte |
| alm_sec_i | input | 8 | Alarm seconds byte |
| alm_min_i | input | 8 | Alarm minutes byte |
| alm_hr_i | input | 8 | Alarm hours byte |
| alarm_o | output | 1 | One-cycle alarm pulse |

## Verification
The hardest case to reach is a 12-hour hit whose current and alarm hour bytes differ in raw form but agree once normalised, such as 12 AM against hour zero, or a PM hour carrying a BCD tens digit. Random stimulus alone almost never lands on such pairs. The bench therefore builds alarm bytes by encoding the current time again in the active mode, so that hits are common, and adds directed pairs for the midnight and noon wraps. Strobe timing cases, namely back-to-back strobes and input changes right after capture, are driven directly.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_FIELDS = 3;
    localparam int FLD_SEC    = 0;
    localparam int FLD_MIN    = 1;
    localparam int FLD_HR     = 2;
    localparam int HALF_DAY   = 12;
    localparam logic [1:0] WILD_TAG = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_FIRE = 2'd2
    } alm_state_e;

endpackage

// File: rtl/rtc_alm_field_dec.sv
module rtc_alm_field_dec
    import rtc_alm_pkg::*;
#(
    parameter int W       = BYTE_W,
    parameter bit IS_HOUR = 1'b0
) (
    input  logic [W-1:0] raw_i,
    input  logic         bin_mode_i,
    input  logic         h24_i,
    output logic [W-1:0] val_o,
    output logic         wild_o
);
    localparam int NIB = W / 2;

    logic         twelve_hr;
    logic [W-1:0] src;
    logic [W-1:0] tens;
    logic [W-1:0] bcd_val;
    logic [W-1:0] plain;
    logic [W-1:0] folded;

    assign twelve_hr = IS_HOUR && !h24_i;
    assign wild_o    = (raw_i[W-1 -: 2] == WILD_TAG);

    always_comb begin
        src = raw_i;
        if (twelve_hr) begin
            src[W-1] = 1'b0;
        end
        tens    = {{(W-NIB){1'b0}}, src[W-1 -: NIB]};
        bcd_val = (tens << 3) + (tens << 1) + {{(W-NIB){1'b0}}, src[NIB-1:0]};
        plain   = bin_mode_i ? src : bcd_val;
        folded  = plain % W'(HALF_DAY);
        if (raw_i[W-1]) begin
            folded = folded + W'(HALF_DAY);
        end
        val_o = twelve_hr ? folded : plain;
    end

endmodule

// File: rtl/rtc_alm_fsm.sv
module rtc_alm_fsm
    import rtc_alm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hit_i,
    output logic fire_o
);
    alm_state_e state_q;
    alm_state_e state_d;
    logic       hit_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hit_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (tick_i) begin
                hit_q <= hit_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        if (tick_i) begin
            state_d = ST_EVAL;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_EVAL: state_d = hit_q ? ST_FIRE : ST_IDLE;
                ST_FIRE: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        fire_o = 1'b0;
        unique case (state_q)
            ST_IDLE: fire_o = 1'b0;
            ST_EVAL: fire_o = 1'b0;
            ST_FIRE: fire_o = 1'b1;
            default: fire_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bin_mode_i,
    input  logic              h24_i,
    input  logic [BYTE_W-1:0] cur_sec_i,
    input  logic [BYTE_W-1:0] cur_min_i,
    input  logic [BYTE_W-1:0] cur_hr_i,
    input  logic [BYTE_W-1:0] alm_sec_i,
    input  logic [BYTE_W-1:0] alm_min_i,
    input  logic [BYTE_W-1:0] alm_hr_i,
    output logic              alarm_o
);
    logic [BYTE_W-1:0] cur_raw [NUM_FIELDS];
    logic [BYTE_W-1:0] alm_raw [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] field_ok;
    logic hit;

    assign cur_raw[FLD_SEC] = cur_sec_i;
    assign cur_raw[FLD_MIN] = cur_min_i;
    assign cur_raw[FLD_HR]  = cur_hr_i;
    assign alm_raw[FLD_SEC] = alm_sec_i;
    assign alm_raw[FLD_MIN] = alm_min_i;
    assign alm_raw[FLD_HR]  = alm_hr_i;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        logic [BYTE_W-1:0] cur_val;
        logic [BYTE_W-1:0] alm_val;
        logic              cur_wild;
        logic              alm_wild;

        rtc_alm_field_dec #(
            .W       (BYTE_W),
            .IS_HOUR (g == FLD_HR)
        ) u_cur (
            .raw_i      (cur_raw[g]),
            .bin_mode_i (bin_mode_i),
            .h24_i      (h24_i),
            .val_o      (cur_val),
            .wild_o     (cur_wild)
        );

        rtc_alm_field_dec #(
            .W       (BYTE_W),
            .IS_HOUR (g == FLD_HR)
        ) u_alm (
            .raw_i      (alm_raw[g]),
            .bin_mode_i (bin_mode_i),
            .h24_i      (h24_i),
            .val_o      (alm_val),
            .wild_o     (alm_wild)
        );

        // a wildcard flag on the current byte carries no meaning
        logic unused_cur_wild;
        assign unused_cur_wild = cur_wild;

        assign field_ok[g] = alm_wild || (cur_val == alm_val);
    end

    assign hit = &field_ok;

    rtc_alm_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .hit_i  (hit),
        .fire_o (alarm_o)
    );

endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic [7:0] alm_sec_i,
    input logic [7:0] alm_min_i,
    input logic [7:0] alm_hr_i,
    input logic       alarm_o
);
    logic all_wild;
    assign all_wild = (alm_sec_i[7:6] == 2'b11) && (alm_min_i[7:6] == 2'b11)
                   && (alm_hr_i[7:6] == 2'b11);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !alarm_o);

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |=> !alarm_o);

    // R10
    needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |-> ($past(tick_i, 2) && !$past(tick_i, 1)));

    // R9
    all_wild_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && all_wild) ##1 !tick_i |=> alarm_o);

endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .alm_sec_i (alm_sec_i),
    .alm_min_i (alm_min_i),
    .alm_hr_i  (alm_hr_i),
    .alarm_o   (alarm_o)
);

// File: tb/sim_rtc_alarm_match.sv
`timescale 1ns/1ps
module sim_rtc_alarm_match;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0;
    logic bin_mode_i = 1'b0;
    logic h24_i = 1'b1;
    logic [7:0] cur_sec_i = 8'h00, cur_min_i = 8'h00, cur_hr_i = 8'h00;
    logic [7:0] alm_sec_i = 8'h00, alm_min_i = 8'h00, alm_hr_i = 8'h00;
    logic alarm_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rtc_alarm_match u0 (.*);

    function automatic int dec(input logic [7:0] b, input bit bin, input bit hr, input bit h24);
        logic [7:0] s;
        int v;
        s = (hr && !h24) ? (b & 8'h7f) : b;
        v = bin ? int'(s) : int'(s[7:4]) * 10 + int'(s[3:0]);
        if (hr && !h24) v = (v % 12) + (b[7] ? 12 : 0);
        return v;
    endfunction

    function automatic bit field_hit(input logic [7:0] c, input logic [7:0] a,
                                     input bit bin, input bit hr, input bit h24);
        if (a[7] && a[6]) return 1'b1;
        return dec(c, bin, hr, h24) == dec(a, bin, hr, h24);
    endfunction

    function automatic logic [7:0] enc(input int v, input bit bin);
        return bin ? 8'(v) : {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [7:0] enc_hr(input int h, input bit bin, input bit h24);
        int h12;
        if (h24) return enc(h, bin);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return enc(h12, bin) | (h >= 12 ? 8'h80 : 8'h00);
    endfunction

    task automatic check(input bit got, input bit exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: alarm_o=%0b expected=%0b", tag, got, exp);
        end
    endtask

    task automatic trial(input bit bin, input bit h24,
                         input logic [7:0] cs, input logic [7:0] cm, input logic [7:0] ch,
                         input logic [7:0] as, input logic [7:0] am, input logic [7:0] ah,
                         input string tag);
        bit exp;
        exp = field_hit(cs, as, bin, 0, h24) && field_hit(cm, am, bin, 0, h24)
              && field_hit(ch, ah, bin, 1, h24);
        @(negedge clk);
        bin_mode_i = bin; h24_i = h24;
        cur_sec_i = cs; cur_min_i = cm; cur_hr_i = ch;
        alm_sec_i = as; alm_min_i = am; alm_hr_i = ah;
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        check(alarm_o, 1'b0, tag);
        @(negedge clk);
        check(alarm_o, exp, tag);
        @(negedge clk);
        check(alarm_o, 1'b0, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(alarm_o, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(alarm_o, 1'b0, "R1 after reset");

        // R9 all wildcards
        trial(0, 1, 8'h17, 8'h42, 8'h09, 8'hC0, 8'hFF, 8'hD5, "R9");
        // R4 hour wildcard, minutes and seconds equal
        trial(1, 1, 8'd33, 8'd12, 8'd7, 8'd33, 8'd12, 8'hE3, "R4");
        // R5 BCD hit
        trial(0, 1, 8'h59, 8'h30, 8'h23, 8'h59, 8'h30, 8'h23, "R5");
        // R6 binary: 0x10 is 16, 0x0A is 10 -> miss
        trial(1, 1, 8'h10, 8'h00, 8'h00, 8'h0A, 8'h00, 8'h00, "R6");
        // R7 12 AM equals hour zero
        trial(0, 0, 8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h00, "R7 midnight");
        // R7 12 PM differs from 12 AM
        trial(0, 0, 8'h00, 8'h00, 8'h92, 8'h00, 8'h00, 8'h12, "R7 noon");
        // R7 PM tens digit
        trial(0, 0, 8'h05, 8'h05, 8'h91, 8'h05, 8'h05, 8'h91, "R7 pm tens");
        // R8 24-hour keeps bit 7
        trial(0, 1, 8'h00, 8'h00, 8'h81, 8'h00, 8'h00, 8'h01, "R8");
        // R11 seconds mismatch only
        trial(0, 1, 8'h11, 8'h22, 8'h03, 8'h12, 8'h22, 8'h03, "R11");

        // R10 matching inputs with no strobe
        @(negedge clk);
        cur_sec_i = 8'h00; alm_sec_i = 8'hC0; alm_min_i = 8'hC0; alm_hr_i = 8'hC0;
        repeat (4) begin
            @(negedge clk);
            check(alarm_o, 1'b0, "R10");
        end

        // R3 hit strobe then miss strobe back to back
        @(negedge clk);
        bin_mode_i = 1; h24_i = 1;
        cur_sec_i = 8'd5; cur_min_i = 8'd5; cur_hr_i = 8'd5;
        alm_sec_i = 8'd5; alm_min_i = 8'd5; alm_hr_i = 8'd5;
        tick_i = 1'b1;
        @(negedge clk);
        alm_sec_i = 8'd6;
        @(negedge clk);
        tick_i = 1'b0;
        check(alarm_o, 1'b0, "R3");
        @(negedge clk);
        check(alarm_o, 1'b0, "R3");
        @(negedge clk);
        check(alarm_o, 1'b0, "R3");

        // R2 inputs changed right after capture are ignored
        @(negedge clk);
        alm_sec_i = 8'd5;
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        alm_sec_i = 8'd40; alm_min_i = 8'd41;
        @(negedge clk);
        check(alarm_o, 1'b1, "R2 capture");
        @(negedge clk);
        check(alarm_o, 1'b0, "R2 one cycle");

        // random trials
        for (int i = 0; i < 600; i++) begin
            bit bin, h24;
            int s, m, h;
            logic [7:0] cs, cm, ch, as, am, ah;
            string tag;
            bin = 1'($urandom % 2);
            h24 = 1'($urandom % 2);
            s = $urandom % 60; m = $urandom % 60; h = $urandom % 24;
            cs = enc(s, bin); cm = enc(m, bin); ch = enc_hr(h, bin, h24);
            as = cs; am = cm; ah = ch;
            case ($urandom % 4)
                0: as = 8'hC0 | 8'($urandom % 64);
                1: am = enc($urandom % 60, bin);
                2: ah = enc_hr($urandom % 24, bin, h24);
                default: ;
            endcase
            if ($urandom % 5 == 0) ah = 8'hC0 | 8'($urandom % 64);
            tag = h24 ? (bin ? "R6 rand" : "R5 rand") : "R7 rand";
            trial(bin, h24, cs, cm, ch, as, am, ah, tag);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule